// File: doc/BRIEF.md
# Audio Primitive Firing Unit

This block evaluates one signal-processing primitive each time a sample strobe arrives. Two signed Q1.15 operands, a Q1.15 parameter word and a three-bit function code select and feed one of several primitives: saturating add, greater-than compare, multiply, parameter-scaled multiply, gain, a computed waveshaping lookup and a scaled pseudo-random noise source. All of the arithmetic work for a sample, including every pointer update, completes within the strobe cycle. The result is registered and appears one clock later with a valid flag.

The result can also pass through a circular delay line. The line's maximum length is a static input. When that input is zero, the line is bypassed. Otherwise the output for a strobe is the primitive result written a number of strobes earlier. That number is recomputed on every strobe from a Q2.14 modulation input, so the delay can be swept at run time, for example to build comb or flanging structures. A new length always takes effect on the following strobe.

Top module: `prim_fire_unit`

## Requirements
- R1: `res_vld` is high exactly in the cycle after a cycle with `smp_vld` high. `res` holds its value when no strobe occurs. After reset, `res` is 0 and `res_vld` is 0.
- R2: Function code 0 gives x1 + x2, saturated to the range 0x8000 to 0x7FFF.
- R3: Function code 1 gives 0x7FFF when x1 > x2 as signed values, and 0x0000 otherwise.
- R4: Function code 2 gives floor(x1·x2 / 2^15), saturated. For example, 0x8000·0x8000 gives 0x7FFF.
- R5: Function code 3 first forms m = saturated floor(x1·x2 / 2^15). It then gives saturated floor(p·m / 2^15).
- R6: Function code 4 gives saturated floor(p·x1 / 2^15).
- R7: Function code 5 forms index k = (x1 + 32768) >> 11 (5 bits) and u = k·2048 − 32768. It gives the saturated value of u + floor(u/2) − floor(w/2), where w = floor(floor(u·u/2^15)·u/2^15).
- R8: Function code 6 gives floor(p·r / 2^15), where r is {0, s[14:0]} and s is a 16-bit shift register. The register is seeded to 0xACE1 by reset. On every strobe, after its value is used, it shifts left and takes s[15]^s[13]^s[12]^s[10] into bit 0.
- R9: Function code 7 gives 0x0000.
- R10: With `max_len` = 0, the result of a strobe appears in the following cycle, with no delay.
- R11: With `max_len` = Λ > 0, the output at strobe n is the result computed at strobe n−L. If no result was written at that point since reset, the output is 0. Here L = clamp(floor(Λ·(tau−16384)/16384), 1, max(Λ−1, 1)), where tau is taken from strobe n−1 (a tau of 16384 or below counts as giving 0). The first strobe after reset uses L = 1.
- R12: A `max_len` above the storage depth (64) acts as a `max_len` equal to the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe; one primitive firing per high cycle |
| op | input | 3 | Function code |
| x1 | input | 16 | First operand, Q1.15 |
| x2 | input | 16 | Second operand, Q1.15 |
| p | input | 16 | Parameter word, Q1.15 |
| tau | input | 16 | Delay modulation, Q2.14, intended range (1, 2) |
| max_len | input | 9 | Static maximum delay length; 0 bypasses the delay line |
| res | output | 16 | Registered result, Q1.15 |
| res_vld | output | 1 | Result valid, one cycle after the strobe |

## Verification
On every strobe, the delay line reads the entry stored with the previous length and writes the new result. In the same cycle, it also latches a new length from the current tau. A read under the old length and a length change therefore fall on the same strobe. The bench provokes this by alternating tau between two values on consecutive back-to-back strobes. It judges each output against a model in which the length used at strobe n comes only from the tau of strobe n−1.

// File: rtl/prim_pkg.sv
package prim_pkg;

    localparam int DATA_W = 16;
    localparam int FRAC_W = 15;
    localparam int WIDE_W = 2 * DATA_W + 2;
    localparam int LFSR_W = 16;

    typedef logic signed [DATA_W-1:0] sample_t;

    typedef enum logic [2:0] {
        OP_SUM   = 3'd0,
        OP_GT    = 3'd1,
        OP_PROD  = 3'd2,
        OP_SPROD = 3'd3,
        OP_GAIN  = 3'd4,
        OP_TABLE = 3'd5,
        OP_NOISE = 3'd6,
        OP_NONE  = 3'd7
    } op_e;

    localparam sample_t S_MAX = sample_t'((1 <<< FRAC_W) - 1);
    localparam sample_t S_MIN = sample_t'(-(1 <<< FRAC_W));
    localparam logic signed [WIDE_W-1:0] W_MAX = (1 <<< FRAC_W) - 1;
    localparam logic signed [WIDE_W-1:0] W_MIN = -(1 <<< FRAC_W);

    // clip a wide signed value into the sample range
    function automatic sample_t sat_wide(input logic signed [WIDE_W-1:0] v);
        if (v > W_MAX) begin
            return S_MAX;
        end else if (v < W_MIN) begin
            return S_MIN;
        end
        return v[DATA_W-1:0];
    endfunction

    // fractional product, floor rounding, clipped
    function automatic sample_t qmul(input sample_t a, input sample_t b);
        logic signed [WIDE_W-1:0] aw;
        logic signed [WIDE_W-1:0] bw;
        logic signed [WIDE_W-1:0] pr;
        aw = WIDE_W'(a);
        bw = WIDE_W'(b);
        pr = aw * bw;
        return sat_wide(pr >>> FRAC_W);
    endfunction

endpackage

// File: rtl/prim_lfsr.sv
module prim_lfsr
    import prim_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [LFSR_W-1:0] state
);

    logic [LFSR_W-1:0] state_d;
    logic [LFSR_W-1:0] state_q;
    logic              fb;

    always_comb begin
        fb      = state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10];
        state_d = state_q;
        if (adv) begin
            state_d = {state_q[LFSR_W-2:0], fb};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/prim_len_calc.sv
module prim_len_calc #(
    parameter int DEPTH    = 64,
    parameter int LEN_W    = 9,
    parameter int TAU_W    = 16,
    parameter int TAU_FRAC = 14
) (
    input  logic [TAU_W-1:0]         tau,
    input  logic [LEN_W-1:0]         lam,
    output logic [$clog2(DEPTH)-1:0] len
);

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PROD_W = LEN_W + TAU_W;
    localparam logic [TAU_W-1:0] TAU_ONE = TAU_W'(1 << TAU_FRAC);

    logic [TAU_W-1:0]  frac;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] raw;
    logic [PROD_W-1:0] hi_w;
    logic [LEN_W-1:0]  hi;
    logic [PROD_W-1:0] pick;

    always_comb begin
        frac = (tau > TAU_ONE) ? (tau - TAU_ONE) : '0;
        prod = {{TAU_W{1'b0}}, lam} * {{LEN_W{1'b0}}, frac};
        raw  = prod >> TAU_FRAC;
        hi   = (lam > LEN_W'(1)) ? (lam - LEN_W'(1)) : LEN_W'(1);
        hi_w = {{TAU_W{1'b0}}, hi};
        if (raw < PROD_W'(1)) begin
            pick = PROD_W'(1);
        end else if (raw > hi_w) begin
            pick = hi_w;
        end else begin
            pick = raw;
        end
        len = pick[ADDR_W-1:0];
    end

endmodule

// File: rtl/prim_delay_line.sv
module prim_delay_line
    import prim_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  sample_t                  din,
    input  logic [$clog2(DEPTH)-1:0] len,
    output sample_t                  dout
);

    localparam int ADDR_W = $clog2(DEPTH);

    sample_t           mem_d [DEPTH];
    sample_t           mem_q [DEPTH];
    logic [ADDR_W-1:0] wr_d;
    logic [ADDR_W-1:0] wr_q;
    logic [ADDR_W-1:0] rd;

    always_comb begin
        mem_d = mem_q;
        wr_d  = wr_q;
        if (we) begin
            mem_d[wr_q] = din;
            wr_d        = wr_q + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
            wr_q <= '0;
        end else begin
            mem_q <= mem_d;
            wr_q  <= wr_d;
        end
    end

    // read trails write by len; len >= 1 keeps it off the slot being written
    assign rd   = wr_q - len;
    assign dout = mem_q[rd];

endmodule

// File: rtl/prim_alu.sv
module prim_alu
    import prim_pkg::*;
#(
    parameter int LUT_AW = 5
) (
    input  op_e     op,
    input  sample_t x1,
    input  sample_t x2,
    input  sample_t p,
    input  sample_t rnd,
    output sample_t res
);

    localparam int LUT_N = 1 << LUT_AW;
    localparam int STEP  = DATA_W - LUT_AW;

    // cubic soft-shaper sampled at the left edge of each bin
    function automatic sample_t shape_at(input int k);
        longint u;
        longint u2;
        longint u3;
        longint f;
        u  = longint'(k <<< STEP) - longint'(1 <<< FRAC_W);
        u2 = (u * u) >>> FRAC_W;
        u3 = (u2 * u) >>> FRAC_W;
        f  = u + (u >>> 1) - (u3 >>> 1);
        return sat_wide(WIDE_W'(f));
    endfunction

    sample_t           lut_tbl [LUT_N];
    logic [DATA_W-1:0] ofs;
    logic [LUT_AW-1:0] idx;
    sample_t           prod_m;
    logic signed [WIDE_W-1:0] a_w;
    logic signed [WIDE_W-1:0] b_w;

    for (genvar k = 0; k < LUT_N; k++) begin : g_lut
        assign lut_tbl[k] = shape_at(k);
    end

    always_comb begin
        a_w    = WIDE_W'(x1);
        b_w    = WIDE_W'(x2);
        ofs    = {~x1[DATA_W-1], x1[DATA_W-2:0]};
        idx    = ofs[DATA_W-1 -: LUT_AW];
        prod_m = qmul(x1, x2);
        unique case (op)
            OP_SUM:   res = sat_wide(a_w + b_w);
            OP_GT:    res = (x1 > x2) ? S_MAX : '0;
            OP_PROD:  res = prod_m;
            OP_SPROD: res = qmul(p, prod_m);
            OP_GAIN:  res = qmul(p, x1);
            OP_TABLE: res = lut_tbl[idx];
            OP_NOISE: res = qmul(p, rnd);
            default:  res = '0;
        endcase
    end

endmodule

// File: rtl/prim_fire_unit.sv
module prim_fire_unit
    import prim_pkg::*;
#(
    parameter int               DEPTH  = 64,
    parameter int               LEN_W  = 9,
    parameter int               TAU_W  = 16,
    parameter int               LUT_AW = 5,
    parameter logic [LFSR_W-1:0] SEED  = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [2:0]        op,
    input  logic signed [15:0] x1,
    input  logic signed [15:0] x2,
    input  logic signed [15:0] p,
    input  logic [TAU_W-1:0]  tau,
    input  logic [LEN_W-1:0]  max_len,
    output logic signed [15:0] res,
    output logic              res_vld
);

    localparam int ADDR_W = $clog2(DEPTH);
    localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(DEPTH);

    typedef struct packed {
        sample_t           res;
        logic              vld;
        logic [ADDR_W-1:0] len;
    } fire_st_t;

    fire_st_t          st_d;
    fire_st_t          st_q;
    logic [LEN_W-1:0]  lam_eff;
    logic [LFSR_W-1:0] lfsr_cur;
    logic [ADDR_W-1:0] len_next;
    logic [ADDR_W-1:0] len_cur;
    sample_t           alu_res;
    sample_t           tap_res;
    sample_t           rnd;

    assign lam_eff = (max_len > DEPTH_L) ? DEPTH_L : max_len;
    assign rnd     = sample_t'({1'b0, lfsr_cur[FRAC_W-1:0]});
    assign len_cur = st_q.len;

    prim_lfsr #(.SEED(SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (smp_vld),
        .state (lfsr_cur)
    );

    prim_alu #(.LUT_AW(LUT_AW)) u_alu (
        .op  (op_e'(op)),
        .x1  (x1),
        .x2  (x2),
        .p   (p),
        .rnd (rnd),
        .res (alu_res)
    );

    prim_len_calc #(
        .DEPTH    (DEPTH),
        .LEN_W    (LEN_W),
        .TAU_W    (TAU_W),
        .TAU_FRAC (TAU_W - 2)
    ) u_len (
        .tau (tau),
        .lam (lam_eff),
        .len (len_next)
    );

    prim_delay_line #(.DEPTH(DEPTH)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (smp_vld),
        .din   (alu_res),
        .len   (st_q.len),
        .dout  (tap_res)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = smp_vld;
        if (smp_vld) begin
            st_d.res = (lam_eff == '0) ? alu_res : tap_res;
            st_d.len = len_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.res <= '0;
            st_q.vld <= 1'b0;
            st_q.len <= ADDR_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign res     = st_q.res;
    assign res_vld = st_q.vld;

endmodule

// File: rtl/prim_fire_unit_chk.sv
module prim_fire_unit_chk #(
    parameter int LEN_W  = 9,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_vld,
    input logic [2:0]        op,
    input logic signed [15:0] x1,
    input logic signed [15:0] x2,
    input logic [LEN_W-1:0]  max_len,
    input logic signed [15:0] res,
    input logic              res_vld,
    input logic [ADDR_W-1:0] len_cur,
    input logic [15:0]       lfsr_cur
);

    a_r1_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> res_vld);

    a_r1_no_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> !res_vld);

    a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(res));

    a_r2_add_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && op == 3'd0 && max_len == '0 && !x1[15] && !x2[15]) |=> !res[15]);

    a_r3_cmp_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && op == 3'd1 && max_len == '0) |=> (res == 16'sh7FFF || res == 16'sh0000));

    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && op == 3'd7 && max_len == '0) |=> (res == 16'sh0000));

    a_r11_len_floor: assert property (@(posedge clk) disable iff (!rst_n)
        len_cur != '0);

    a_r11_len_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (max_len > LEN_W'(1)) |-> (LEN_W'(len_cur) < max_len));

    a_r8_noise_alive: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_cur != 16'h0000);

endmodule

bind prim_fire_unit prim_fire_unit_chk #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_vld  (smp_vld),
    .op       (op),
    .x1       (x1),
    .x2       (x2),
    .max_len  (max_len),
    .res      (res),
    .res_vld  (res_vld),
    .len_cur  (len_cur),
    .lfsr_cur (lfsr_cur)
);

// File: tb/prim_fire_unit_tb_top.sv
`timescale 1ns/1ps
module prim_fire_unit_tb_top;

    localparam int LEN_W = 9;
    localparam int DEPTH = 64;
    localparam int NVEC  = 20;

    // {op, x1, x2, p, expected}
    localparam logic [66:0] VEC [NVEC] = '{
        {3'd0, 16'h4000, 16'h2000, 16'h0000, 16'h6000},
        {3'd0, 16'h7000, 16'h7000, 16'h0000, 16'h7FFF},
        {3'd0, 16'h9000, 16'h9000, 16'h0000, 16'h8000},
        {3'd0, 16'h8000, 16'hFFFF, 16'h0000, 16'h8000},
        {3'd1, 16'h0100, 16'h00FF, 16'h0000, 16'h7FFF},
        {3'd1, 16'hFF00, 16'h0001, 16'h0000, 16'h0000},
        {3'd1, 16'h1234, 16'h1234, 16'h0000, 16'h0000},
        {3'd2, 16'h4000, 16'h4000, 16'h0000, 16'h2000},
        {3'd2, 16'h8000, 16'h8000, 16'h0000, 16'h7FFF},
        {3'd2, 16'h4000, 16'hC000, 16'h0000, 16'hE000},
        {3'd3, 16'h8000, 16'h8000, 16'h4000, 16'h3FFF},
        {3'd3, 16'h4000, 16'h4000, 16'hC000, 16'hF000},
        {3'd4, 16'h6000, 16'h0000, 16'h4000, 16'h3000},
        {3'd4, 16'h8000, 16'h0000, 16'h8000, 16'h7FFF},
        {3'd4, 16'hFFFF, 16'h0000, 16'h2000, 16'hFFFF},
        {3'd5, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
        {3'd5, 16'h8000, 16'h0000, 16'h0000, 16'h8000},
        {3'd5, 16'h7FFF, 16'h0000, 16'h0000, 16'h7F44},
        {3'd5, 16'hC000, 16'h0000, 16'h0000, 16'hA800},
        {3'd7, 16'h5555, 16'h1111, 16'h2222, 16'h0000}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               smp_vld = 1'b0;
    logic [2:0]         op = 3'd0;
    logic signed [15:0] x1 = '0;
    logic signed [15:0] x2 = '0;
    logic signed [15:0] p = '0;
    logic [15:0]        tau = 16'h4000;
    logic [LEN_W-1:0]   max_len = '0;
    logic signed [15:0] res;
    logic               res_vld;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    prim_fire_unit dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_vld (smp_vld),
        .op      (op),
        .x1      (x1),
        .x2      (x2),
        .p       (p),
        .tau     (tau),
        .max_len (max_len),
        .res     (res),
        .res_vld (res_vld)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic do_reset(input logic [LEN_W-1:0] lam);
        @(negedge clk);
        rst_n   = 1'b0;
        smp_vld = 1'b0;
        max_len = lam;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic fire(input logic [2:0] f, input logic [15:0] a, input logic [15:0] b,
                        input logic [15:0] pp, input logic [15:0] t);
        op      = f;
        x1      = a;
        x2      = b;
        p       = pp;
        tau     = t;
        smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    function automatic string tag_of(input logic [2:0] f);
        case (f)
            3'd0: return "R2 add";
            3'd1: return "R3 cmp";
            3'd2: return "R4 mul";
            3'd3: return "R5 scaled mul";
            3'd4: return "R6 gain";
            3'd5: return "R7 lookup";
            default: return "R9 reserved";
        endcase
    endfunction

    // delay length from the rule in R11 and R12
    function automatic int len_of(input int lam, input int t);
        int lam_e;
        int raw;
        int hi;
        lam_e = (lam > DEPTH) ? DEPTH : lam;
        raw   = (t > 16384) ? ((lam_e * (t - 16384)) >>> 14) : 0;
        hi    = (lam_e > 1) ? lam_e - 1 : 1;
        if (raw < 1) raw = 1;
        if (raw > hi) raw = hi;
        return raw;
    endfunction

    task automatic run_delay(input string tag, input int lam, input int ta, input int tb, input int cnt);
        int vals [128];
        int taus [128];
        do_reset(LEN_W'(lam));
        for (int n = 0; n < cnt; n++) begin
            int ln;
            int e;
            vals[n] = (n + 1) * 97;
            taus[n] = (n % 2 == 0) ? ta : tb;
            ln = (n == 0) ? 1 : len_of(lam, taus[n-1]);
            e  = (n - ln >= 0) ? vals[n - ln] : 0;
            fire(3'd0, 16'(vals[n]), 16'h0000, 16'h0000, 16'(taus[n]));
            check(tag, res, 16'(e));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog got=hung exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        logic [15:0] r;

        // R1 reset state
        do_reset('0);
        check("R1 reset res", res, 16'h0000);
        check("R1 reset vld", {15'd0, res_vld}, 16'h0001 ^ 16'h0001);

        // table walk, delay bypassed (R10)
        for (int i = 0; i < NVEC; i++) begin
            logic [66:0] v;
            v = VEC[i];
            fire(v[66:64], v[63:48], v[47:32], v[31:16], 16'h4000);
            check(tag_of(v[66:64]), res, v[15:0]);
        end

        // R10 result of a single strobe visible next cycle, R1 valid and hold
        fire(3'd0, 16'h1111, 16'h2222, 16'h0000, 16'h4000);
        check("R10 no delay", res, 16'h3333);
        check("R1 valid", {15'd0, res_vld}, 16'h0001);
        held = res;
        repeat (3) @(negedge clk);
        check("R1 hold value", res, held);
        check("R1 idle valid", {15'd0, res_vld}, 16'h0000);

        // R8 noise from shift register
        do_reset('0);
        r = 16'hACE1;
        for (int n = 0; n < 6; n++) begin
            logic [15:0] pp;
            longint e;
            pp = (n % 2 == 0) ? 16'h7FFF : 16'h8000;
            e  = (longint'($signed(pp)) * longint'({1'b0, r[14:0]})) >>> 15;
            fire(3'd6, 16'h0000, 16'h0000, pp, 16'h4000);
            check("R8 noise", res, 16'(e));
            r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
        end

        // R11 modulated delay: mid length, minimum clamp, maximum clamp
        run_delay("R11 len3", 8, 22938, 22938, 12);
        run_delay("R11 len1 clamp", 8, 16384, 16384, 6);
        run_delay("R11 top clamp", 8, 32767, 32767, 12);
        run_delay("R11 single slot", 1, 30000, 30000, 5);
        // length changing every strobe while reading
        run_delay("R11 alternating", 8, 22938, 32767, 20);
        // R12 oversize maximum length
        run_delay("R12 depth clamp", 300, 32767, 32767, 70);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule